// File: doc/BRIEF.md
# Serial Control Word Loader

This block takes 8-bit control words from a serial control line that shares its time slots with PCM data. A low-active strobe opens an 8-bit window; one bit is captured on each clock edge of the window, most significant bit first. A three-level address input, carried as a 2-bit code, decides where each completed word goes. It can go to the function register (A), to the drive register (B), or to register A while register B is cleared. A word sent to register B blocks PCM transfer for that window. A typical frame carries an A-window with the PCM slot, then a second B-window later in the same frame.

Register A is split into a transmit gain code, a receive gain code and a 2-bit function (normal, digital loopback, analog loopback, powerdown). Register B is split into six discrete drive outputs and a 2-bit test-mode field. When no strobe has been seen for a whole frame and the address sits at its lowest level, the static level of the serial line picks the mode directly. A low level gives normal operation at 0 dB. A high level forces powerdown. After reset both registers hold the powerdown state, and they refuse new words for a fixed number of cycles.

Top module: `ctl_word_loader`

## Requirements
- R1: Bits are captured on rising clock edges while `strobe_n` is low, first bit as bit 7. The address is taken at the first bit of the window. The decoded outputs change on the edge after the one that captured the eighth bit.
- R2: A window that closes before eight bits have been captured changes nothing. Bits captured after the eighth in the same window are ignored.
- R3: Address code 2'b00 (low) loads the word into register A and clears register B to zero, so every drive output and the test field read 0.
- R4: Address code 2'b01 (mid) loads the word into register A and leaves register B unchanged.
- R5: Address code 2'b10 (high) loads the word into register B and leaves register A unchanged. `pcm_en` is high only while `strobe_n` is low and the address is 2'b00 or 2'b01.
- R6: A word whose window address is 2'b11 is discarded.
- R7: Register A decodes as transmit gain = bits 2..0, receive gain = bits 5..3, and function = bits 7..6. The function codes are 00 normal, 01 digital loopback, 10 analog loopback and 11 powerdown.
- R8: Register B decodes as drive outputs = bits 5..0 (1 = active) and test mode = bits 7..6 (00 = normal).
- R9: Reset sets register A to 8'hC0 (powerdown, gains 0) and register B to 0. A word whose load edge is among the first HOLD_CYC edges after reset release is discarded.
- R10: After FRAME_CYC consecutive edges with `strobe_n` high, and while the address is 2'b00, the outputs show gains 0 and a function taken from the serial line: 00 when it is low and 11 when it is high. Registers A and B are not altered by this, and they reappear once the condition ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_n | input | 1 | Low-active window enable |
| addr_lvl | input | 2 | Three-level address code: 00 low, 01 mid, 10 high, 11 reserved |
| ctl_in | input | 1 | Serial control data, or static mode level |
| pcm_en | output | 1 | PCM transfer allowed in this window |
| tx_gain | output | 3 | Transmit gain code, 0..7 dB |
| rx_gain | output | 3 | Receive attenuation code, 0..7 dB |
| func_sel | output | 2 | Function: normal, digital loop, analog loop, powerdown |
| drive_out | output | 6 | Discrete drive outputs, 1 = active |
| test_mode | output | 2 | Test-mode field, 00 = normal |

## Verification
Two functions can meet on one edge: the first edge after the post-reset hold, and the load of a completed word. The bench releases reset and then places a mid-address window so that its load edge falls one edge inside the hold, then a second time exactly on the first permitted edge. It expects the powerdown state to survive the first case and the new gains to appear in the second. The same load-versus-clear interplay is also exercised by random low, mid, high and reserved windows, some cut short and some overlong, each judged against a bench model of both registers.

// File: rtl/cwl_pkg.sv
// Package: shared codes for the serial control word loader.
// Assumes an 8-bit control word; the field layout below is fixed by the decode.
package cwl_pkg;

    localparam int WORD_W = 8;
    localparam int GAIN_W = 3;
    localparam int DRV_W  = 6;

    typedef enum logic [1:0] {
        ADDR_LOW  = 2'b00,
        ADDR_MID  = 2'b01,
        ADDR_HIGH = 2'b10,
        ADDR_RSVD = 2'b11
    } addr_lvl_e;

    typedef enum logic [1:0] {
        FN_NORMAL   = 2'b00,
        FN_DIG_LOOP = 2'b01,
        FN_ANA_LOOP = 2'b10,
        FN_PWRDN    = 2'b11
    } func_e;

    // Reset value of register A: powerdown, both gains zero.
    localparam logic [WORD_W-1:0] REG_A_RST = {FN_PWRDN, {(WORD_W-2){1'b0}}};

endpackage

// File: rtl/cwl_shifter.sv
// Module: cwl_shifter
// Captures one serial word per strobe window, MSB first, and emits a
// one-cycle valid with the word and the address seen at its first bit.
// Assumes the window lasts at least WORD_W edges; shorter ones are dropped.
module cwl_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic [1:0]        addr_i,
    input  logic              ser_i,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o,
    output logic [1:0]        word_addr_o
);
    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
    localparam logic [CW-1:0] FULL = CW'(WORD_W);

    logic [CW-1:0]     bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic [1:0]        addr_q;
    logic [WORD_W-1:0] next_word;
    logic [1:0]        win_addr;

    assign next_word = {shreg[WORD_W-2:0], ser_i};
    assign win_addr  = (bit_cnt == '0) ? addr_i : addr_q;

    // Shift bits in during the window and flag the eighth one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            shreg       <= '0;
            addr_q      <= 2'b00;
            word_vld_o  <= 1'b0;
            word_o      <= '0;
            word_addr_o <= 2'b00;
        end else begin
            word_vld_o <= 1'b0;
            if (strobe_n) begin
                bit_cnt <= '0;
            end else if (bit_cnt != FULL) begin
                addr_q  <= win_addr;
                shreg   <= next_word;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST) begin
                    word_vld_o  <= 1'b1;
                    word_o      <= next_word;
                    word_addr_o <= win_addr;
                end
            end
        end
    end

endmodule

// File: rtl/cwl_regs.sv
// Module: cwl_regs
// Holds control registers A and B and applies the address rules to each
// completed word. Assumes a valid pulse lasts a single cycle. Words are
// refused until HOLD_CYC edges have passed since reset release.
module cwl_regs
    import cwl_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int HOLD_CYC = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [1:0]        word_addr_i,
    output logic              hold_done_o,
    output logic [WORD_W-1:0] reg_a_o,
    output logic [WORD_W-1:0] reg_b_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_END = HW'(HOLD_CYC);

    logic [HW-1:0] hold_cnt;

    assign hold_done_o = (hold_cnt == HOLD_END);

    // Count the post-reset hold and saturate at its end.
    always_ff @(posedge clk) begin
        if (!rst_n)           hold_cnt <= '0;
        else if (!hold_done_o) hold_cnt <= hold_cnt + 1'b1;
    end

    // Steer a completed word into A, B, or A with B cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_a_o <= REG_A_RST[WORD_W-1:0];
            reg_b_o <= '0;
        end else if (word_vld_i && hold_done_o) begin
            unique case (addr_lvl_e'(word_addr_i))
                ADDR_LOW: begin
                    reg_a_o <= word_i;
                    reg_b_o <= '0;
                end
                ADDR_MID:  reg_a_o <= word_i;
                ADDR_HIGH: reg_b_o <= word_i;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/cwl_idle_mon.sv
// Module: cwl_idle_mon
// Flags a frame with no strobe: counts consecutive edges with the strobe
// high and saturates at FRAME_CYC. Assumes FRAME_CYC >= 1.
module cwl_idle_mon #(
    parameter int FRAME_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic idle_o
);
    localparam int IW = $clog2(FRAME_CYC + 1);
    localparam logic [IW-1:0] IDLE_END = IW'(FRAME_CYC);

    logic [IW-1:0] idle_cnt;

    assign idle_o = (idle_cnt == IDLE_END);

    // Restart on any strobe, otherwise count up to the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)        idle_cnt <= '0;
        else if (!strobe_n) idle_cnt <= '0;
        else if (!idle_o)   idle_cnt <= idle_cnt + 1'b1;
    end

endmodule

// File: rtl/cwl_decode.sv
// Module: cwl_decode
// Splits registers A and B into their fields. While static mode is
// selected, the serial line level replaces the A fields. Purely combinational.
module cwl_decode
    import cwl_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int GAIN_W = 3,
    parameter int DRV_W  = 6
) (
    input  logic [WORD_W-1:0] reg_a_i,
    input  logic [WORD_W-1:0] reg_b_i,
    input  logic              static_sel_i,
    input  logic              ser_lvl_i,
    output logic [GAIN_W-1:0] tx_gain_o,
    output logic [GAIN_W-1:0] rx_gain_o,
    output logic [1:0]        func_o,
    output logic [DRV_W-1:0]  drive_o,
    output logic [1:0]        test_o
);
    // Pick the register fields or the static-level override for A.
    always_comb begin
        if (static_sel_i) begin
            tx_gain_o = '0;
            rx_gain_o = '0;
            func_o    = ser_lvl_i ? FN_PWRDN : FN_NORMAL;
        end else begin
            tx_gain_o = reg_a_i[GAIN_W-1:0];
            rx_gain_o = reg_a_i[2*GAIN_W-1:GAIN_W];
            func_o    = reg_a_i[WORD_W-1:WORD_W-2];
        end
    end

    // Register B fields map straight to the drive and test outputs.
    always_comb begin
        drive_o = reg_b_i[DRV_W-1:0];
        test_o  = reg_b_i[WORD_W-1:WORD_W-2];
    end

endmodule

// File: rtl/ctl_word_loader.sv
// Module: ctl_word_loader (top)
// Serial control word loader. Shifts in words, steers them to register
// A or B by address level, decodes both and handles static-level mode.
// Assumes one clock domain and a synchronous active-low reset.
module ctl_word_loader
    import cwl_pkg::*;
#(
    parameter int HOLD_CYC  = 25,
    parameter int FRAME_CYC = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_n,
    input  logic [1:0] addr_lvl,
    input  logic       ctl_in,
    output logic       pcm_en,
    output logic [2:0] tx_gain,
    output logic [2:0] rx_gain,
    output logic [1:0] func_sel,
    output logic [5:0] drive_out,
    output logic [1:0] test_mode
);
    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic [1:0]        word_addr;
    logic              hold_done;
    logic [WORD_W-1:0] reg_a;
    logic [WORD_W-1:0] reg_b;
    logic              idle;
    logic              static_sel;

    // PCM may move only in windows addressed low or mid.
    always_comb begin
        pcm_en = !strobe_n && ((addr_lvl == ADDR_LOW) || (addr_lvl == ADDR_MID));
    end

    // Static mode needs a strobe-free frame and the low address.
    always_comb begin
        static_sel = idle && (addr_lvl == ADDR_LOW);
    end

    cwl_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_n    (strobe_n),
        .addr_i      (addr_lvl),
        .ser_i       (ctl_in),
        .word_vld_o  (word_vld),
        .word_o      (word),
        .word_addr_o (word_addr)
    );

    cwl_regs #(.WORD_W(WORD_W), .HOLD_CYC(HOLD_CYC)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_vld_i  (word_vld),
        .word_i      (word),
        .word_addr_i (word_addr),
        .hold_done_o (hold_done),
        .reg_a_o     (reg_a),
        .reg_b_o     (reg_b)
    );

    cwl_idle_mon #(.FRAME_CYC(FRAME_CYC)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .idle_o   (idle)
    );

    cwl_decode #(.WORD_W(WORD_W), .GAIN_W(GAIN_W), .DRV_W(DRV_W)) u_dec (
        .reg_a_i      (reg_a),
        .reg_b_i      (reg_b),
        .static_sel_i (static_sel),
        .ser_lvl_i    (ctl_in),
        .tx_gain_o    (tx_gain),
        .rx_gain_o    (rx_gain),
        .func_o       (func_sel),
        .drive_o      (drive_out),
        .test_o       (test_mode)
    );

endmodule

// File: rtl/cwl_checker.sv
// Module: cwl_checker
// Temporal properties of the loader, bound into the top module.
module cwl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr_lvl,
    input logic       ctl_in,
    input logic       pcm_en,
    input logic [2:0] tx_gain,
    input logic [1:0] func_sel,
    input logic       word_vld,
    input logic [1:0] word_addr,
    input logic       hold_done,
    input logic [7:0] reg_a,
    input logic [7:0] reg_b,
    input logic       static_sel
);
    // R2: a register only changes on the edge after a completed word
    p_no_partial_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(reg_a) || !$stable(reg_b)) |-> $past(word_vld));

    // R9: nothing loads during the post-reset hold
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_done |=> ($stable(reg_a) && $stable(reg_b)));

    // R3: a low-address word leaves register B cleared
    p_clear_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && hold_done && word_addr == 2'b00) |=> (reg_b == 8'h00));

    // R5: a high-address word never disturbs register A
    p_keep_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_addr == 2'b10) |=> $stable(reg_a));

    // R5: PCM is inhibited whenever the high address is present
    p_pcm_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_lvl == 2'b10) |-> !pcm_en);

    // R10: a high static level forces powerdown at zero gain
    p_static_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (static_sel && ctl_in) |-> (func_sel == 2'b11 && tx_gain == 3'd0));

endmodule

bind ctl_word_loader cwl_checker u_cwl_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_lvl   (addr_lvl),
    .ctl_in     (ctl_in),
    .pcm_en     (pcm_en),
    .tx_gain    (tx_gain),
    .func_sel   (func_sel),
    .word_vld   (word_vld),
    .word_addr  (word_addr),
    .hold_done  (hold_done),
    .reg_a      (reg_a),
    .reg_b      (reg_b),
    .static_sel (static_sel)
);

// File: tb/test_ctl_word_loader.sv
// Bench for ctl_word_loader: directed corners plus seeded random windows,
// compared with a bench model of registers A and B.
module test_ctl_word_loader;
    localparam int HOLD  = 25;
    localparam int FRAME = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_n = 1'b1;
    logic [1:0] addr_lvl = 2'b00;
    logic       ctl_in = 1'b0;
    logic       pcm_en;
    logic [2:0] tx_gain, rx_gain;
    logic [1:0] func_sel, test_mode;
    logic [5:0] drive_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] m_a, m_b;

    always #4 clk = ~clk;

    ctl_word_loader #(.HOLD_CYC(HOLD), .FRAME_CYC(FRAME)) i_ctl_word_loader (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .addr_lvl(addr_lvl),
        .ctl_in(ctl_in), .pcm_en(pcm_en), .tx_gain(tx_gain), .rx_gain(rx_gain),
        .func_sel(func_sel), .drive_out(drive_out), .test_mode(test_mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply the register rules to the model (R3, R4, R5, R6).
    task automatic model_load(input logic [1:0] a, input logic [7:0] w);
        case (a)
            2'b00: begin m_a = w; m_b = 8'h00; end
            2'b01: m_a = w;
            2'b10: m_b = w;
            default: ;
        endcase
    endtask

    // Compare every decoded output with the model (R7, R8).
    task automatic chk_all(input string req);
        chk({req, " R7 tx"},   int'(tx_gain),   int'(m_a[2:0]));
        chk({req, " R7 rx"},   int'(rx_gain),   int'(m_a[5:3]));
        chk({req, " R7 func"}, int'(func_sel),  int'(m_a[7:6]));
        chk({req, " R8 drv"},  int'(drive_out), int'(m_b[5:0]));
        chk({req, " R8 test"}, int'(test_mode), int'(m_b[7:6]));
    endtask

    // Called at a negedge: drive nbits bits MSB first, then close the window.
    task automatic send(input logic [1:0] a, input logic [7:0] w, input int nbits,
                        input bit chk_pcm);
        for (int i = 0; i < nbits; i++) begin
            strobe_n = 1'b0;
            addr_lvl = a;
            ctl_in   = (i < 8) ? w[7-i] : 1'($urandom);
            if (chk_pcm && i == 0) begin
                #1;
                chk("R5 pcm_en", int'(pcm_en), (a == 2'b00 || a == 2'b01) ? 1 : 0);
            end
            @(negedge clk);
        end
        strobe_n = 1'b1;
        addr_lvl = 2'b01;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        strobe_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_a = 8'hC0;
        m_b = 8'h00;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [1:0] ra;
        logic [7:0] rw;
        int nb;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        // R9: reset state
        chk_all("R9 reset");

        // R9: load edge on hold edge HOLD is refused (first bit at edge HOLD-8)
        repeat (HOLD - 9) @(negedge clk);
        send(2'b01, 8'h12, 8, 0);
        chk_all("R9 hold reject");

        // R9: load edge HOLD+1 is the first accepted
        do_reset();
        repeat (HOLD - 8) @(negedge clk);
        send(2'b01, 8'h12, 8, 0);
        model_load(2'b01, 8'h12);
        chk_all("R9 hold accept");

        // R5, R8: high address fills B, leaves A
        send(2'b10, 8'hFF, 8, 1);
        model_load(2'b10, 8'hFF);
        chk_all("R5 load B");
        // R4: mid address keeps B
        send(2'b01, 8'h8D, 8, 1);
        model_load(2'b01, 8'h8D);
        chk_all("R4 keep B");
        // R3: low address clears B
        send(2'b00, 8'h47, 8, 1);
        model_load(2'b00, 8'h47);
        chk_all("R3 clear B");
        // R6: reserved address discarded
        send(2'b11, 8'h3C, 8, 1);
        chk_all("R6 reserved");
        // R1: bit order, 8'h01 vs 8'h80
        send(2'b01, 8'h01, 8, 0);
        model_load(2'b01, 8'h01);
        chk_all("R1 lsb word");
        send(2'b01, 8'h80, 8, 0);
        model_load(2'b01, 8'h80);
        chk_all("R1 msb word");
        // R2: short window and overlong window
        send(2'b01, 8'hFF, 7, 0);
        chk_all("R2 short");
        send(2'b01, 8'hA9, 11, 0);
        model_load(2'b01, 8'hA9);
        chk_all("R2 long");

        // Random windows (R1..R8)
        for (int k = 0; k < 80; k++) begin
            ra = 2'($urandom);
            rw = 8'($urandom);
            case ($urandom % 6)
                0:       nb = 1 + int'($urandom % 7);
                1:       nb = 9 + int'($urandom % 3);
                default: nb = 8;
            endcase
            send(ra, rw, nb, 1);
            if (nb >= 8) model_load(ra, rw);
            chk_all("R1 random");
            repeat (int'($urandom % 4)) @(negedge clk);
        end

        // R10: static level mode
        send(2'b01, 8'h5B, 8, 0);
        model_load(2'b01, 8'h5B);
        addr_lvl = 2'b00;
        ctl_in = 1'b0;
        repeat (FRAME + 2) @(negedge clk);
        chk("R10 static low func", int'(func_sel), 0);
        chk("R10 static low tx", int'(tx_gain), 0);
        ctl_in = 1'b1;
        #1;
        chk("R10 static high func", int'(func_sel), 3);
        chk("R10 static high rx", int'(rx_gain), 0);
        addr_lvl = 2'b01;
        #1;
        chk_all("R10 static released");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule